// File: doc/BRIEF.md
# Privileged and Illegal Instruction Trap Entry

This block sits at the execute stage of a simple in-order core. For each issued instruction it receives the decoded operation class, the raw instruction word, the decoder's illegal-instruction flag, the instruction's address and the live 64-bit machine state register. It decides whether the instruction may write back its results, must trap, or halts the core.

A trap happens in two cases. The first is a privileged operation issued while the machine state register shows problem (user) state. The second is an instruction that the decoder has flagged as illegal. On a trap the block produces the values for the two save/restore registers and for the new machine state, with write strobes. It also gives a one-cycle redirect pulse that carries the vector address, which fetch loads as its next address.

An attention (halt) operation sets a sticky halted flag. While that flag is set, the block ignores every further issue. Only a synchronous reset clears the flag.

Top module: `trap_entry_unit`

## Requirements
- R1: Operation classes are coded on 4 bits: 0 plain, 1 attention, 2 read-MSR, 3 write-MSR, 4 write-MSR-doubleword, 5 interrupt-return, 6 read-SPR, 7 write-SPR. Classes 1 to 5 are always privileged.
- R2: Classes 6 and 7 are privileged only when bit 20 of the instruction word (bit 0 = least significant) is 1. With bit 20 at 0 they execute normally even in problem state.
- R3: A privileged operation issued while MSR bit 14 (problem state) is 1 traps. One cycle after issue the redirect pulse is high with address 0x700, and the saved MSR has the privileged cause bit 18 set.
- R4: An issued instruction with the illegal flag set traps to 0x700, and the saved MSR has cause bit 19 set. When the privileged trap of R3 also applies, that trap takes precedence and only bit 18 is added.
- R5: On a trap the first save register receives the address of the trapping instruction itself, not that address plus 4.
- R6: On a trap the second save register receives the MSR value from before the trap, with the cause bit ORed in. All other bits are copied unchanged.
- R7: The new MSR written on a trap has bits 63 (64-bit mode) and 0 (little-endian) set to 1. It has bits 32, 25, 23, 15, 14, 13, 12, 11, 10, 9, 8, 5, 4, 2 and 1 cleared. Every other bit keeps its old value.
- R8: An instruction that traps gets no writeback permission. An accepted instruction that neither traps nor halts gives a one-cycle writeback-permission pulse one cycle after issue, with no trap strobes.
- R9: An attention operation that does not trap sets the halted flag one cycle after issue, even if the illegal flag is also set. It gives neither writeback permission nor a redirect.
- R10: While halted, issued instructions cause no redirect, no strobe and no writeback permission. The flag is cleared only by synchronous reset.
- R11: While reset is asserted, all strobes, the redirect pulse, the writeback permission and the halted flag are 0 after the next clock edge.
- R12: Each trapping issue gives exactly one cycle of redirect, together with the save and MSR write strobes. Back-to-back trapping issues give back-to-back pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_valid | input | 1 | An instruction is presented this cycle |
| op_class | input | 4 | Decoded operation class (R1 coding) |
| insn_word | input | 32 | Raw instruction word |
| illegal | input | 1 | Decoder flags the instruction as illegal |
| cur_addr | input | 64 | Address of the presented instruction |
| msr_in | input | 64 | Live machine state register |
| retire_ok | output | 1 | Writeback permitted for the instruction issued last cycle |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_addr | output | 64 | Vector address for the redirect |
| save_we | output | 1 | Write strobe for both save/restore registers |
| save_pc | output | 64 | Value for the first save register |
| save_msr | output | 64 | Value for the second save register |
| msr_we | output | 1 | Write strobe for the live MSR |
| msr_next | output | 64 | New MSR value |
| halted | output | 1 | Sticky halted flag |

## Verification
Each result of this block is registered once. The strobes, redirect, writeback permission, data values and the halted flag for an issue all become visible in the cycle after the clock edge that sampled the issue. The driver presents exactly one stimulus per cycle, just after the falling edge. With each stimulus it queues the results the requirements predict. The monitor takes one queued item per rising edge and compares it a short delay after that edge, so each result is checked in the one cycle it belongs to. Idle and halted cycles also queue items, so a pulse that is missing, late or stretched shows up as a mismatch.

// File: rtl/trap_pkg.sv
// Package: shared constants for trap entry.
// Holds the operation-class coding and the machine-state bit positions
// (bit 0 = least significant) that neighbouring logic also decodes.
package trap_pkg;

    localparam int unsigned MSR_W = 64;

    typedef enum logic [3:0] {
        OPC_PLAIN     = 4'd0,
        OPC_HALT      = 4'd1,
        OPC_RD_MSR    = 4'd2,
        OPC_WR_MSR    = 4'd3,
        OPC_WR_MSR64  = 4'd4,
        OPC_INT_RET   = 4'd5,
        OPC_RD_SPR    = 4'd6,
        OPC_WR_SPR    = 4'd7
    } op_class_e;

    // Machine-state bit positions.
    localparam int unsigned MB_WIDE64    = 63;
    localparam int unsigned MB_TXN       = 32;
    localparam int unsigned MB_VECU      = 25;
    localparam int unsigned MB_VSXU      = 23;
    localparam int unsigned MB_EXT_EN    = 15;
    localparam int unsigned MB_PROBLEM   = 14;
    localparam int unsigned MB_FPU       = 13;
    localparam int unsigned MB_UNDEF     = 12;
    localparam int unsigned MB_FPX0      = 11;
    localparam int unsigned MB_STEP_TRC  = 10;
    localparam int unsigned MB_BR_TRC    = 9;
    localparam int unsigned MB_FPX1      = 8;
    localparam int unsigned MB_I_XLATE   = 5;
    localparam int unsigned MB_D_XLATE   = 4;
    localparam int unsigned MB_PERF_MARK = 2;
    localparam int unsigned MB_RECOVER   = 1;
    localparam int unsigned MB_LITTLE    = 0;

    // Cause bits ORed into the saved machine state.
    localparam int unsigned CAUSE_ILLEGAL = 19;
    localparam int unsigned CAUSE_PRIV    = 18;

    localparam logic [MSR_W-1:0] ONE = {{(MSR_W-1){1'b0}}, 1'b1};

    localparam logic [MSR_W-1:0] MSR_SET_MASK =
        (ONE << MB_WIDE64) | (ONE << MB_LITTLE);

    localparam logic [MSR_W-1:0] MSR_CLR_MASK =
        (ONE << MB_TXN)      | (ONE << MB_VECU)     | (ONE << MB_VSXU)    |
        (ONE << MB_EXT_EN)   | (ONE << MB_PROBLEM)  | (ONE << MB_FPU)     |
        (ONE << MB_UNDEF)    | (ONE << MB_FPX0)     | (ONE << MB_STEP_TRC)|
        (ONE << MB_BR_TRC)   | (ONE << MB_FPX1)     | (ONE << MB_I_XLATE) |
        (ONE << MB_D_XLATE)  | (ONE << MB_PERF_MARK)| (ONE << MB_RECOVER);

endpackage

// File: rtl/trap_classify.sv
// Module: trap_classify
// Decides from the operation class and one selector bit of the raw
// instruction whether the operation is privileged, and flags the halt
// operation. Purely combinational; assumes a valid class coding.
module trap_classify
    import trap_pkg::*;
#(
    parameter int unsigned SPR_SEL_BIT = 20
) (
    input  logic [3:0] op_class,
    input  logic       spr_sel,
    output logic       is_priv,
    output logic       is_halt
);

    op_class_e opc;
    assign opc = op_class_e'(op_class);

    // Classify the operation by its class and the move-selector bit.
    always_comb begin
        is_priv = 1'b0;
        is_halt = 1'b0;
        case (opc)
            OPC_HALT: begin
                is_priv = 1'b1;
                is_halt = 1'b1;
            end
            OPC_RD_MSR, OPC_WR_MSR, OPC_WR_MSR64, OPC_INT_RET:
                is_priv = 1'b1;
            OPC_RD_SPR, OPC_WR_SPR:
                is_priv = spr_sel;
            default: begin
                is_priv = 1'b0;
                is_halt = 1'b0;
            end
        endcase
    end

    // R1: halt is always a privileged class
    always_comb begin
        if (is_halt) begin
            assert (is_priv) else $error("a_r1_halt_priv");
        end
    end

endmodule

// File: rtl/trap_msr_gen.sv
// Module: trap_msr_gen
// Builds the saved machine state (old value with a cause bit ORed in)
// and the new machine state (fixed set/clear pattern, other bits kept).
// Purely combinational; assumes the package masks do not overlap.
module trap_msr_gen
    import trap_pkg::*;
(
    input  logic [MSR_W-1:0] old_msr,
    input  logic             cause_priv,
    output logic [MSR_W-1:0] saved_msr,
    output logic [MSR_W-1:0] new_msr
);

    logic [MSR_W-1:0] cause_vec;

    // Select the single cause bit for this trap.
    always_comb begin
        cause_vec = cause_priv ? (ONE << CAUSE_PRIV) : (ONE << CAUSE_ILLEGAL);
    end

    // Saved copy: old state plus the cause.
    always_comb begin
        saved_msr = old_msr | cause_vec;
    end

    // Per-bit selection of the new state.
    for (genvar b = 0; b < MSR_W; b++) begin : g_bit
        if (MSR_SET_MASK[b]) begin : g_set
            assign new_msr[b] = 1'b1;
        end else if (MSR_CLR_MASK[b]) begin : g_clr
            assign new_msr[b] = 1'b0;
        end else begin : g_keep
            assign new_msr[b] = old_msr[b];
        end
    end

    // R6: exactly one cause bit is added.
    always_comb begin
        assert ($countones(cause_vec) == 1) else $error("a_r6_one_cause");
    end

endmodule

// File: rtl/trap_entry_unit.sv
// Module: trap_entry_unit
// Execute-stage trap entry: checks privilege against problem state, then
// halt, then the illegal flag. It registers the writeback permission, the
// trap strobes and data, the redirect pulse and the sticky halted flag.
// All results appear one cycle after issue. Assumes the MSR input is the
// live value at issue and that the save/MSR registers sit outside.
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned INSN_W      = 32,
    parameter int unsigned SPR_SEL_BIT = 20,
    parameter logic [ADDR_W-1:0] VECTOR = 64'h700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [3:0]        op_class,
    input  logic [INSN_W-1:0] insn_word,
    input  logic              illegal,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [MSR_W-1:0]  msr_in,
    output logic              retire_ok,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              save_we,
    output logic [ADDR_W-1:0] save_pc,
    output logic [MSR_W-1:0]  save_msr,
    output logic              msr_we,
    output logic [MSR_W-1:0]  msr_next,
    output logic              halted
);

    localparam logic [ADDR_W-1:0] ZERO_ADDR = '0;

    logic spr_sel;
    logic unused_insn_bits;
    logic is_priv, is_halt;
    logic accept, priv_trap, halt_go, ill_trap, take_trap;
    logic [MSR_W-1:0] saved_val, new_val;

    assign spr_sel          = insn_word[SPR_SEL_BIT];
    assign unused_insn_bits = ^{insn_word[INSN_W-1:SPR_SEL_BIT+1],
                                insn_word[SPR_SEL_BIT-1:0]};

    trap_classify #(.SPR_SEL_BIT(SPR_SEL_BIT)) u_classify (
        .op_class (op_class),
        .spr_sel  (spr_sel),
        .is_priv  (is_priv),
        .is_halt  (is_halt)
    );

    trap_msr_gen u_msr_gen (
        .old_msr    (msr_in),
        .cause_priv (priv_trap),
        .saved_msr  (saved_val),
        .new_msr    (new_val)
    );

    // Priority: privilege in problem state, then halt, then illegal.
    always_comb begin
        accept    = issue_valid & ~halted;
        priv_trap = accept & is_priv & msr_in[MB_PROBLEM];
        halt_go   = accept & ~priv_trap & is_halt;
        ill_trap  = accept & ~priv_trap & ~is_halt & illegal;
        take_trap = priv_trap | ill_trap;
    end

    // Control pulses and the sticky halted flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retire_ok      <= 1'b0;
            redirect_valid <= 1'b0;
            save_we        <= 1'b0;
            msr_we         <= 1'b0;
            halted         <= 1'b0;
        end else begin
            retire_ok      <= accept & ~take_trap & ~halt_go;
            redirect_valid <= take_trap;
            save_we        <= take_trap;
            msr_we         <= take_trap;
            halted         <= halted | halt_go;
        end
    end

    // Trap data, loaded only when a trap is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_addr <= '0;
            save_pc       <= '0;
            save_msr      <= '0;
            msr_next      <= '0;
        end else begin
            redirect_addr <= take_trap ? VECTOR : ZERO_ADDR;
            if (take_trap) begin
                save_pc  <= cur_addr;
                save_msr <= saved_val;
                msr_next <= new_val;
            end
        end
    end

    // R12: redirect comes with vector and both strobes
    a_r12_redirect_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (redirect_addr == VECTOR) && save_we && msr_we);

    // R8: trapping instruction never retires
    a_r8_no_writeback_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> !retire_ok);

    // R5: saved address is the faulting instruction address
    a_r5_save_pc: assert property (@(posedge clk) disable iff (!rst_n)
        save_we |-> save_pc == $past(cur_addr));

    // R6: saved state matches old state outside the cause bits
    a_r6_save_copy: assert property (@(posedge clk) disable iff (!rst_n)
        save_we |-> ((save_msr ^ $past(msr_in)) &
                     ~((ONE << CAUSE_PRIV) | (ONE << CAUSE_ILLEGAL))) == '0);

    // R7: new state leaves problem state, forces 64-bit and little-endian
    a_r7_new_msr: assert property (@(posedge clk) disable iff (!rst_n)
        msr_we |-> !msr_next[MB_PROBLEM] && msr_next[MB_WIDE64] && msr_next[MB_LITTLE]);

    // R10: halted is sticky
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10: nothing issues while halted
    a_r10_halt_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !redirect_valid && !retire_ok && !save_we && !msr_we);

endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [3:0]  op_class = '0;
    logic [31:0] insn_word = '0;
    logic        illegal = 1'b0;
    logic [63:0] cur_addr = '0;
    logic [63:0] msr_in = '0;
    logic        retire_ok, redirect_valid, save_we, msr_we, halted;
    logic [63:0] redirect_addr, save_pc, save_msr, msr_next;

    int total = 0;
    int bad = 0;
    bit model_halted = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit          redir;
        bit          retire;
        bit          halt;
        logic [63:0] pc;
        logic [63:0] smsr;
        logic [63:0] nmsr;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .op_class(op_class), .insn_word(insn_word), .illegal(illegal),
        .cur_addr(cur_addr), .msr_in(msr_in), .retire_ok(retire_ok),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .save_we(save_we), .save_pc(save_pc), .save_msr(save_msr),
        .msr_we(msr_we), .msr_next(msr_next), .halted(halted)
    );

    function automatic logic [63:0] ref_new_msr(logic [63:0] old);
        int clr[15] = '{32, 25, 23, 15, 14, 13, 12, 11, 10, 9, 8, 5, 4, 2, 1};
        logic [63:0] v = old;
        foreach (clr[i]) v[clr[i]] = 1'b0;
        v[63] = 1'b1;
        v[0]  = 1'b1;
        return v;
    endfunction

    // Driver: one stimulus per cycle, expected result queued alongside.
    task automatic drive(bit v, logic [3:0] opc, bit sel, bit ill,
                         logic [63:0] addr, logic [63:0] msr, string tag);
        exp_t e;
        bit priv, trap_p, trap_i, hlt;
        @(negedge clk);
        rst_n       = 1'b1;
        issue_valid = v;
        op_class    = opc;
        insn_word   = sel ? 32'h0010_0000 : 32'h7C00_02A6;
        illegal     = ill;
        cur_addr    = addr;
        msr_in      = msr;
        priv   = (opc >= 4'd1 && opc <= 4'd5) || ((opc == 4'd6 || opc == 4'd7) && sel);
        trap_p = v && !model_halted && priv && msr[14];
        hlt    = v && !model_halted && !trap_p && opc == 4'd1;
        trap_i = v && !model_halted && !trap_p && !hlt && ill;
        e.redir  = trap_p || trap_i;
        e.retire = v && !model_halted && !e.redir && !hlt;
        model_halted = model_halted || hlt;
        e.halt = model_halted;
        e.pc   = addr;
        e.smsr = msr | (64'd1 << (trap_p ? 18 : 19));
        e.nmsr = ref_new_msr(msr);
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic do_reset(string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0;
        issue_valid = 1'b0;
        model_halted = 1'b0;
        e.redir = 0; e.retire = 0; e.halt = 0;
        e.pc = '0; e.smsr = '0; e.nmsr = '0; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares one item per rising edge, after the edge settles.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            bit ok;
            e = q.pop_front();
            total++;
            ok = (redirect_valid == e.redir) && (save_we == e.redir) &&
                 (msr_we == e.redir) && (retire_ok == e.retire) && (halted == e.halt);
            if (e.redir)
                ok = ok && (redirect_addr == 64'h700) && (save_pc == e.pc) &&
                     (save_msr == e.smsr) && (msr_next == e.nmsr);
            if (!ok) begin
                bad++;
                $display("FAIL %s: act redir=%0b ret=%0b hlt=%0b addr=%h pc=%h smsr=%h nmsr=%h exp redir=%0b ret=%0b hlt=%0b pc=%h smsr=%h nmsr=%h",
                         e.tag, redirect_valid, retire_ok, halted, redirect_addr, save_pc,
                         save_msr, msr_next, e.redir, e.retire, e.halt, e.pc, e.smsr, e.nmsr);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (retire_ok || redirect_valid || save_we || msr_we || halted) begin
            bad++;
            $display("FAIL R11: act ret=%0b redir=%0b sw=%0b mw=%0b hlt=%0b exp all 0",
                     retire_ok, redirect_valid, save_we, msr_we, halted);
        end
        // R8: plain op retires in problem state
        drive(1, 4'd0, 0, 0, 64'h1000, 64'h4000, "R8 plain retire");
        drive(0, 4'd0, 0, 0, 64'h0, 64'h0, "R8 idle");
        // R1: privileged class in supervisor state retires
        drive(1, 4'd2, 0, 0, 64'h1004, 64'h0, "R1 rd-msr supervisor");
        // R1 R3 R5 R6 R7: privileged in problem state traps
        drive(1, 4'd2, 0, 0, 64'h1008, 64'h4000, "R3 rd-msr problem");
        drive(1, 4'd3, 0, 0, 64'h2000, 64'hFFFF_FFFF_FFFF_FFFF, "R7 wr-msr all ones");
        drive(1, 4'd4, 0, 0, 64'h2004, 64'h0000_0000_0000_4000, "R7 wr-msr64");
        drive(1, 4'd5, 0, 0, 64'hDEAD_BEEF_0000_1230, 64'h8000_1234_5678_C000, "R5 int-ret pc");
        drive(0, 4'd0, 0, 0, 64'h0, 64'h0, "R12 pulse ends");
        // R2: SPR moves
        drive(1, 4'd6, 0, 0, 64'h3000, 64'h4000, "R2 rd-spr sel0 retire");
        drive(1, 4'd6, 1, 0, 64'h3004, 64'h4000, "R2 rd-spr sel1 trap");
        drive(1, 4'd7, 0, 0, 64'h3008, 64'h4000, "R2 wr-spr sel0 retire");
        drive(1, 4'd7, 1, 0, 64'h300C, 64'h4000, "R2 wr-spr sel1 trap");
        drive(1, 4'd7, 1, 0, 64'h3010, 64'h0, "R2 wr-spr sel1 supervisor");
        // R4: illegal and priority
        drive(1, 4'd0, 0, 1, 64'h4000, 64'h0000_0000_0000_0021, "R4 illegal supervisor");
        drive(1, 4'd3, 0, 1, 64'h4004, 64'h4000, "R4 priv beats illegal");
        drive(1, 4'd0, 0, 1, 64'h4008, 64'h4000, "R4 illegal problem");
        drive(1, 4'd2, 0, 1, 64'h400C, 64'h0, "R4 illegal priv-class supervisor");
        drive(0, 4'd0, 0, 0, 64'h0, 64'h0, "R12 idle after back-to-back");
        // R3: halt class in problem state traps instead of halting
        drive(1, 4'd1, 0, 0, 64'h5000, 64'h4000, "R3 halt in problem state");
        // R9: halt in supervisor state, even with illegal flag
        drive(1, 4'd1, 0, 1, 64'h5004, 64'h0, "R9 halt");
        // R10: issues ignored while halted
        drive(1, 4'd3, 0, 1, 64'h5008, 64'h4000, "R10 trap ignored");
        drive(1, 4'd0, 0, 0, 64'h500C, 64'h0, "R10 plain ignored");
        drive(0, 4'd0, 0, 0, 64'h0, 64'h0, "R10 still halted");
        // R10 R11: reset clears halt
        do_reset("R11 reset clears halt");
        drive(1, 4'd0, 0, 0, 64'h6000, 64'h0, "R10 retire after reset");
        drive(0, 4'd0, 0, 0, 64'h0, 64'h0, "R8 final idle");
        repeat (3) @(posedge clk);
        #4;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule